// File: doc/BRIEF.md
# One-Hot CPU Clock Prescaler

This block turns an oscillator-rate clock into a CPU clock enable. Software selects the divide ratio by writing a 6-bit select field held in the low bits of an 8-bit configuration register. Each supported ratio is chosen by a single set bit in that field: the lowest bit gives a ratio of two, and each higher bit doubles it, up to sixty-four. An all-zero field means no division. Any field with two or more set bits is treated as invalid and falls back to the slowest ratio, sixty-four.

The register answers at one fixed address on a simple write/read port, and the read data is combinational. A free-running counter runs inside a two-state machine. In state `DIV_BYPASS` (ratio one) the enable is held high. In state `DIV_COUNT` the enable pulses for one oscillator cycle each time the counter reaches the terminal count. A newly written ratio is picked up only at a terminal count, so no enable interval is ever shortened or stretched to a value that is neither the old ratio nor the new one.

State transitions happen only on a terminal cycle, when the active ratio is reloaded:
- `DIV_BYPASS` to `DIV_COUNT` (`BYP_TO_CNT`) when the register asks for a ratio above one.
- `DIV_COUNT` to `DIV_BYPASS` (`CNT_TO_BYP`) when the register asks for ratio one.
- Otherwise the state holds (`BYP_HOLD`, `CNT_HOLD`).

Top module: `cpu_prescaler`

## Requirements
- R1: A synchronous active-high reset clears both the select field and the counter. From the first cycle after reset the block divides by one, with the enable high on every cycle.
- R2: The register decodes at address 0x2E. A cycle with `bus_wr` high and that address stores `bus_wdata[5:0]` at the clock edge. While `bus_addr` is 0x2E, `bus_rdata` shows `{2'b00, field}` in the same cycle; at any other address it reads 0x00.
- R3: Bits 7:6 of the register always read as zero, and writes to those bits have no effect.
- R4: A write cycle at any address other than 0x2E leaves the select field unchanged.
- R5: Field value 000000 selects ratio 1, and `cpu_clk_en` is high on every oscillator cycle.
- R6: A field with only bit i set (i = 0..5) selects ratio 2^(i+1). `cpu_clk_en` is then high for exactly one cycle in every 2^(i+1) cycles.
- R7: Every field value with two or more bits set selects ratio 64.
- R8: A new ratio takes effect at the next terminal count. The enable interval in progress when the write happens completes at the old ratio, and the intervals after it use the new ratio.
- R9: While the ratio is above one, an enable pulse is never followed by another enable pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register port address |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| cpu_clk_en | output | 1 | CPU clock enable, one oscillator cycle wide per period |

## Verification
The bench sweeps all 64 field values and measures the spacing between enable pulses. A decoder that mis-ranks the one-hot bits gives the wrong doubling, and one that passes invalid codes through gives a ratio other than 64. In a directed case a fast ratio is written partway through a slow interval. A design that reloads the ratio at once would cut that interval short and produce a runt period instead of the full 64 cycles. Random writes that mix addresses and upper-bit data expose stray decoding and writable upper bits. A reset in the middle of a run checks that the enable goes back to high on every cycle.

// File: rtl/cpu_prescaler_pkg.sv
package cpu_prescaler_pkg;

    localparam int PSC_SEL_W  = 6;
    localparam int PSC_DATA_W = 8;
    localparam int PSC_ADDR_W = 8;
    localparam logic [PSC_ADDR_W-1:0] PSC_CFG_ADDR = 8'h2E;

    typedef enum logic {
        DIV_BYPASS = 1'b0,
        DIV_COUNT  = 1'b1
    } div_state_t;

endpackage

// File: rtl/psc_cfg_reg.sv
module psc_cfg_reg #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 6,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2E
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SEL_W-1:0]  sel
);

    localparam int PAD_W = DATA_W - SEL_W;

    logic             hit;
    logic [SEL_W-1:0] sel_q;

    assign hit = (addr == CFG_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
        end else if (wr && hit) begin
            sel_q <= wdata[SEL_W-1:0];
        end
    end

    always_comb begin
        rdata = '0;
        if (hit) begin
            rdata = {{PAD_W{1'b0}}, sel_q};
        end
    end

    assign sel = sel_q;

endmodule

// File: rtl/psc_ratio_decode.sv
module psc_ratio_decode #(
    parameter int SEL_W = 6
) (
    input  logic [SEL_W-1:0] sel,
    output logic [SEL_W-1:0] term
);

    localparam logic [SEL_W-1:0] TERM_SLOWEST = '1;

    logic [SEL_W-1:0] bit_match;
    logic [SEL_W-1:0] term_of [SEL_W];

    for (genvar i = 0; i < SEL_W; i++) begin : g_code
        localparam logic [SEL_W-1:0] CODE   = SEL_W'(1) << i;
        localparam logic [SEL_W:0]   RATIO  = (SEL_W+1)'(1) << (i + 1);
        localparam logic [SEL_W:0]   TERM_W = RATIO - (SEL_W+1)'(1);
        assign bit_match[i] = (sel == CODE);
        assign term_of[i]   = TERM_W[SEL_W-1:0];
    end

    always_comb begin
        term = TERM_SLOWEST;
        if (sel == '0) begin
            term = '0;
        end else begin
            for (int i = 0; i < SEL_W; i++) begin
                if (bit_match[i]) begin
                    term = term_of[i];
                end
            end
        end
    end

endmodule

// File: rtl/psc_div_fsm.sv
module psc_div_fsm
    import cpu_prescaler_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] term_req,
    output logic [CNT_W-1:0] term_active,
    output logic [CNT_W-1:0] cnt,
    output logic             en
);

    div_state_t       state_q, state_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CNT_W-1:0] term_q, term_nx;
    logic             at_term;

    assign at_term = (cnt_q == term_q);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= DIV_BYPASS;
            cnt_q   <= '0;
            term_q  <= '0;
        end else begin
            state_q <= state_nx;
            cnt_q   <= cnt_nx;
            term_q  <= term_nx;
        end
    end

    // next state: reload only on a terminal cycle
    always_comb begin
        state_nx = state_q;
        cnt_nx   = cnt_q;
        term_nx  = term_q;
        unique case (state_q)
            DIV_BYPASS: begin
                cnt_nx   = '0;
                term_nx  = term_req;
                state_nx = (term_req == '0) ? DIV_BYPASS : DIV_COUNT;
            end
            DIV_COUNT: begin
                if (at_term) begin
                    cnt_nx   = '0;
                    term_nx  = term_req;
                    state_nx = (term_req == '0) ? DIV_BYPASS : DIV_COUNT;
                end else begin
                    cnt_nx = cnt_q + CNT_W'(1);
                end
            end
            default: begin
                state_nx = DIV_BYPASS;
                cnt_nx   = '0;
                term_nx  = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            DIV_BYPASS: en = 1'b1;
            DIV_COUNT:  en = at_term;
            default:    en = 1'b0;
        endcase
    end

    assign term_active = term_q;
    assign cnt         = cnt_q;

endmodule

// File: rtl/cpu_prescaler.sv
module cpu_prescaler
    import cpu_prescaler_pkg::*;
#(
    parameter int ADDR_W = PSC_ADDR_W,
    parameter int DATA_W = PSC_DATA_W,
    parameter int SEL_W  = PSC_SEL_W,
    parameter logic [ADDR_W-1:0] CFG_ADDR = PSC_CFG_ADDR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              cpu_clk_en
);

    localparam int CNT_W = SEL_W;

    logic [SEL_W-1:0] cfg_sel;
    logic [CNT_W-1:0] term_req;
    logic [CNT_W-1:0] term_active;
    logic [CNT_W-1:0] div_cnt;

    psc_cfg_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SEL_W   (SEL_W),
        .CFG_ADDR(CFG_ADDR)
    ) u_cfg (
        .clk  (clk),
        .rst  (rst),
        .addr (bus_addr),
        .wr   (bus_wr),
        .wdata(bus_wdata),
        .rdata(bus_rdata),
        .sel  (cfg_sel)
    );

    psc_ratio_decode #(
        .SEL_W(SEL_W)
    ) u_dec (
        .sel (cfg_sel),
        .term(term_req)
    );

    psc_div_fsm #(
        .CNT_W(CNT_W)
    ) u_div (
        .clk        (clk),
        .rst        (rst),
        .term_req   (term_req),
        .term_active(term_active),
        .cnt        (div_cnt),
        .en         (cpu_clk_en)
    );

endmodule

// File: rtl/cpu_prescaler_chk.sv
module cpu_prescaler_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int SEL_W  = 6,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h2E
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              cpu_clk_en,
    input logic [SEL_W-1:0]  cfg_sel,
    input logic [SEL_W-1:0]  term_active,
    input logic [SEL_W-1:0]  div_cnt
);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst) $past(rst) |-> (cfg_sel == '0 && div_cnt == '0 && cpu_clk_en)); // R1
    AST_WRITE_STORES: assert property (@(posedge clk) disable iff (rst) ($past(bus_wr && bus_addr == CFG_ADDR && !rst)) |-> (cfg_sel == $past(bus_wdata[SEL_W-1:0]))); // R2
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst) bus_rdata[DATA_W-1:SEL_W] == '0); // R3
    AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (rst) ($past(!rst && !(bus_wr && bus_addr == CFG_ADDR))) |-> $stable(cfg_sel)); // R4
    AST_BYPASS_HIGH: assert property (@(posedge clk) disable iff (rst) (term_active == '0) |-> cpu_clk_en); // R5
    AST_RATIO_POW2: assert property (@(posedge clk) disable iff (rst) $countones({1'b0, term_active} + (SEL_W+1)'(1)) == 1); // R6
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) div_cnt <= term_active); // R6
    AST_RELOAD_AT_TERM: assert property (@(posedge clk) disable iff (rst) ($past(!cpu_clk_en && !rst)) |-> $stable(term_active)); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst) (cpu_clk_en && term_active != '0) |=> (div_cnt == '0)); // R9

endmodule

bind cpu_prescaler cpu_prescaler_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .SEL_W   (SEL_W),
    .CFG_ADDR(CFG_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .cpu_clk_en (cpu_clk_en),
    .cfg_sel    (cfg_sel),
    .term_active(term_active),
    .div_cnt    (div_cnt)
);

// File: tb/cpu_prescaler_test.sv
module cpu_prescaler_test;

    localparam logic [7:0] CFG = 8'h2E;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       cpu_clk_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    cpu_prescaler uut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cpu_clk_en(cpu_clk_en)
    );

    function automatic int exp_ratio(input logic [5:0] code);
        if (code == 6'd0) return 1;
        for (int i = 0; i < 6; i++) begin
            if (code == (6'd1 << i)) return 1 << (i + 1);
        end
        return 64;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_addr  = CFG;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!cpu_clk_en);
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!cpu_clk_en);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int n;
        logic [5:0] model;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        bus_addr = CFG;
        // R1: reset state
        check("R1 rdata", bus_rdata, 0);
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R1 en", cpu_clk_en, 1);
        end

        // R5/R6/R7: sweep all codes, upper bits random (R3)
        for (int c = 0; c < 64; c++) begin
            logic [7:0] d;
            d = {2'($urandom()), 6'(c)};
            write_reg(CFG, d);
            check("R3 readback", bus_rdata, c);
            wait_pulse();
            measure(n);
            check(c == 0 ? "R5 ratio" : ($countones(6'(c)) == 1 ? "R6 ratio" : "R7 ratio"), n, exp_ratio(6'(c)));
            measure(n);
            check("R9 steady ratio", n, exp_ratio(6'(c)));
        end

        // R8: write fast ratio mid-interval of a slow one
        write_reg(CFG, 8'h20);
        wait_pulse();
        measure(n);
        check("R8 settle", n, 64);
        n = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            n++;
        end
        write_reg(CFG, 8'h01);
        n++;
        while (!cpu_clk_en) begin
            @(negedge clk);
            n++;
        end
        check("R8 old interval", n, 64);
        measure(n);
        check("R8 new interval", n, 2);

        // R8: slow ratio written during a fast run
        write_reg(CFG, 8'h04);
        wait_pulse();
        measure(n);
        check("R8 to 8", n, 8);

        // R2/R3/R4: random register traffic
        model = 6'h04;
        for (int k = 0; k < 40; k++) begin
            logic [7:0] a;
            logic [7:0] d;
            a = ($urandom() % 3 == 0) ? 8'($urandom()) : CFG;
            d = 8'($urandom());
            bus_addr  = a;
            bus_wdata = d;
            bus_wr    = 1'b1;
            @(negedge clk);
            bus_wr = 1'b0;
            if (a == CFG) model = d[5:0];
            check(a == CFG ? "R2 other-addr read" : "R4 other-addr read", bus_rdata, 0 + (a == CFG ? int'(model) : 0));
            bus_addr = CFG;
            #0.1;
            check(a == CFG ? "R2 write" : "R4 ignored", bus_rdata, model);
        end
        @(negedge clk);

        // R3: upper bits ignored
        write_reg(CFG, 8'hFF);
        check("R3 upper zero", bus_rdata, 8'h3F);
        wait_pulse();
        measure(n);
        check("R7 all ones", n, 64);

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset clears", bus_rdata, 0);
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check("R1 en after reset", cpu_clk_en, 1);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule